// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

The block refreshes a five-position LED panel of four seven-segment digits and one dot position by time multiplexing. It visits the positions one after another. For each visit it shifts that position's 8-bit segment byte out over a clock/data pair into an external serial-in, parallel-out register. It then drives that position's enable low, and only that one, for a fixed dwell time set by an internal timer. The digits are common anode, so a segment lights when its line is low. The block passes the bytes to the panel unchanged: a 0 bit means lit.

A host writes the five segment bytes into a small register file through a one-cycle write strobe. The scanner copies a position's byte into its shift register when it starts the visit to that position. A write therefore shows up at the next visit to that position. All enables stay high while a byte is being shifted, so the external register's moving outputs never reach a lit digit.

Top module: `segScanner`

## Requirements
- R1: After reset all position enables are high, the serial clock is low, and every segment register holds 8'hFF (all segments dark).
- R2: Each visit shifts exactly SEG_W bits, most significant bit first. The data line changes only in the cycle where the serial clock falls, or before the first rise, and it is steady while the clock is high.
- R3: At most one position enable is low at any time, and no enable is low while the serial clock is high or toggling.
- R4: Positions are enabled in the order 0, 1, 2, 3, 4, and the scan then returns to 0.
- R5: Each position's enable stays low for exactly DWELL_CYCLES clock cycles.
- R6: Consecutive rising edges of the serial clock are 2*SCLK_HALF cycles apart. The enables stay all high for exactly 1 + 2*SCLK_HALF*SEG_W cycles between two dwells.
- R7: A byte written to position p is shifted out at the first visit to p that begins after the write. The visit already in progress, whether shifting or lit, keeps the old byte.
- R8: Writes with an address of NUM_POS or higher change no segment register.
- R9: The byte shifted out for a position equals that position's register contents, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the segment registers |
| wrAddr | input | $clog2(NUM_POS) | Position index being written |
| wrData | input | SEG_W | Segment byte, 0 = segment lit |
| sclk | output | 1 | Serial clock to the external shift register, idle low |
| sdo | output | 1 | Serial data, sampled externally on the rising sclk edge |
| posEnN | output | NUM_POS | Active-low position enables |

## Verification
A visit lasts one load cycle, then 2*SCLK_HALF*SEG_W shift cycles, then DWELL_CYCLES lit cycles. The bench samples on the falling clock edge. It captures sdo on each observed sclk rise and counts cycles between events. It checks every bit interval, the enable-high gap and the dwell length against those counts. Host writes are issued only in the middle of a dwell, well clear of the load cycle. Each frame's expected byte is taken from the bench's shadow registers at the moment the enables go high, so whether a write falls before or after the load is never in doubt.

// File: rtl/segScanPkg.sv
package segScanPkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_SHOW  = 2'd2
  } scanState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } scanStrobe_t;
endpackage

// File: rtl/segScanCtl.sv
module segScanCtl
  import segScanPkg::*;
#(
  parameter int NUM_POS      = 5,
  parameter int SEG_W        = 8,
  parameter int SCLK_HALF    = 2,
  parameter int DWELL_CYCLES = 50000,
  localparam int POS_W  = $clog2(NUM_POS),
  localparam int BIT_W  = $clog2(SEG_W),
  localparam int HALF_W = $clog2(SCLK_HALF + 1),
  localparam int DW_W   = $clog2(DWELL_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  output scanStrobe_t        strobe,
  output logic [POS_W-1:0]   pos,
  output logic               sclk,
  output logic [NUM_POS-1:0] posEnN
);
  scanState_t        state;
  logic [BIT_W-1:0]  bitCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [DW_W-1:0]   dwellCnt;
  logic              phaseHi;
  logic              halfDone;
  logic              lastBit;

  assign halfDone = (halfCnt == HALF_W'(SCLK_HALF - 1));
  assign lastBit  = (bitCnt == BIT_W'(SEG_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      pos      <= '0;
      bitCnt   <= '0;
      halfCnt  <= '0;
      dwellCnt <= '0;
      phaseHi  <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: begin
          state   <= ST_SHIFT;
          bitCnt  <= '0;
          halfCnt <= '0;
          phaseHi <= 1'b0;
        end
        ST_SHIFT: begin
          if (halfDone) begin
            halfCnt <= '0;
            if (!phaseHi) begin
              phaseHi <= 1'b1;
            end else if (lastBit) begin
              phaseHi  <= 1'b0;
              state    <= ST_SHOW;
              dwellCnt <= '0;
            end else begin
              phaseHi <= 1'b0;
              bitCnt  <= bitCnt + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_SHOW: begin
          if (dwellCnt == DW_W'(DWELL_CYCLES - 1)) begin
            state <= ST_LOAD;
            pos   <= (pos == POS_W'(NUM_POS - 1)) ? '0 : pos + 1'b1;
          end else begin
            dwellCnt <= dwellCnt + 1'b1;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == ST_LOAD);
    strobe.shift = (state == ST_SHIFT) && halfDone && phaseHi && !lastBit;
  end

  assign sclk = (state == ST_SHIFT) && phaseHi;

  for (genvar i = 0; i < NUM_POS; i++) begin : g_en
    assign posEnN[i] = !((state == ST_SHOW) && (pos == POS_W'(i)));
  end
endmodule

// File: rtl/segScanData.sv
module segScanData
  import segScanPkg::*;
#(
  parameter int NUM_POS = 5,
  parameter int SEG_W   = 8,
  localparam int POS_W  = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [POS_W-1:0] wrAddr,
  input  logic [SEG_W-1:0] wrData,
  input  scanStrobe_t      strobe,
  input  logic [POS_W-1:0] pos,
  output logic             sdo
);
  logic [SEG_W-1:0] segReg [NUM_POS];
  logic [SEG_W-1:0] shiftReg;
  logic [SEG_W-1:0] selByte;

  for (genvar i = 0; i < NUM_POS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        segReg[i] <= '1;
      else if (wrEn && (wrAddr == POS_W'(i)))
        segReg[i] <= wrData;
    end
  end

  always_comb begin
    selByte = '1;
    for (int i = 0; i < NUM_POS; i++)
      if (pos == POS_W'(i)) selByte = segReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      shiftReg <= '1;
    else if (strobe.load)
      shiftReg <= selByte;
    else if (strobe.shift)
      shiftReg <= {shiftReg[SEG_W-2:0], 1'b1};
  end

  assign sdo = shiftReg[SEG_W-1];
endmodule

// File: rtl/segScanner.sv
module segScanner
  import segScanPkg::*;
#(
  parameter int NUM_POS      = 5,
  parameter int SEG_W        = 8,
  parameter int SCLK_HALF    = 2,
  parameter int DWELL_CYCLES = 50000,
  localparam int POS_W = $clog2(NUM_POS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [POS_W-1:0]   wrAddr,
  input  logic [SEG_W-1:0]   wrData,
  output logic               sclk,
  output logic               sdo,
  output logic [NUM_POS-1:0] posEnN
);
  scanStrobe_t      strobe;
  logic [POS_W-1:0] pos;

  segScanCtl #(
    .NUM_POS(NUM_POS), .SEG_W(SEG_W),
    .SCLK_HALF(SCLK_HALF), .DWELL_CYCLES(DWELL_CYCLES)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pos(pos),
    .sclk(sclk), .posEnN(posEnN)
  );

  segScanData #(.NUM_POS(NUM_POS), .SEG_W(SEG_W)) i_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .pos(pos), .sdo(sdo)
  );
endmodule

// File: rtl/segScannerChk.sv
module segScannerChk #(
  parameter int NUM_POS = 5,
  localparam int POS_W  = $clog2(NUM_POS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclk,
  input logic               sdo,
  input logic [NUM_POS-1:0] posEnN
);
  logic             shownNow;
  logic             shownPrev;
  logic             seenOne;
  logic [POS_W-1:0] lastPos;
  logic [POS_W-1:0] curIdx;
  logic [POS_W-1:0] nextPos;

  assign shownNow = !(&posEnN);
  assign nextPos  = (lastPos == POS_W'(NUM_POS - 1)) ? '0 : lastPos + 1'b1;

  always_comb begin
    curIdx = '0;
    for (int i = 0; i < NUM_POS; i++)
      if (!posEnN[i]) curIdx = POS_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shownPrev <= 1'b0;
      seenOne   <= 1'b0;
      lastPos   <= '0;
    end else begin
      shownPrev <= shownNow;
      if (shownNow && !shownPrev) begin
        seenOne <= 1'b1;
        lastPos <= curIdx;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&posEnN && !sclk));

  a_r3_one_enable: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~posEnN) <= 1);

  a_r3_dark_while_shifting: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> &posEnN);

  a_r2_data_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(sdo));

  a_r4_scan_order: assert property (@(posedge clk) disable iff (!rstN)
    (shownNow && !shownPrev && seenOne) |-> (curIdx == nextPos));

  a_r5_no_direct_switch: assert property (@(posedge clk) disable iff (!rstN)
    (shownNow && shownPrev) |-> $stable(posEnN));
endmodule

bind segScanner segScannerChk #(.NUM_POS(NUM_POS)) i_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdo(sdo), .posEnN(posEnN)
);

// File: tb/test_segScanner.sv
module test_segScanner;
  localparam int NP    = 5;
  localparam int SW    = 8;
  localparam int HALF  = 2;
  localparam int DWELL = 20;
  localparam int GAP   = 1 + 2 * HALF * SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [SW-1:0] wrData = '0;
  logic          sclk, sdo;
  logic [NP-1:0] posEnN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  logic [SW-1:0] shadow [NP];

  segScanner #(.NUM_POS(NP), .SEG_W(SW), .SCLK_HALF(HALF), .DWELL_CYCLES(DWELL))
    i_segScanner (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                  .wrData(wrData), .sclk(sclk), .sdo(sdo), .posEnN(posEnN));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: sample away from the active edge
  logic          prevSclk = 1'b0;
  logic          prevLit = 1'b0;
  logic [SW-1:0] capByte = '0;
  logic [SW-1:0] expByte = '1;
  int            bitCount = 0;
  int            sinceRise = 0;
  int            gapCnt = 0;
  int            dwellCnt = 0;
  int            expPos = 0;
  bit            firstFrame = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      logic lit;
      lit = !(&posEnN);
      sinceRise++;
      if (sclk && !prevSclk) begin
        if (bitCount > 0) chk(sinceRise == 2 * HALF, "R6 bit spacing", sinceRise, 2 * HALF);
        capByte = {capByte[SW-2:0], sdo};
        bitCount++;
        sinceRise = 0;
      end else if (sclk && prevSclk) begin
        chk(sdo == capByte[0], "R2 data steady while clock high", sdo, capByte[0]);
      end
      if (sclk && lit) chk(1'b0, "R3 enable low during shift", posEnN, 5'h1f);
      if (lit && !prevLit) begin
        chk(bitCount == SW, "R2 bit count", bitCount, SW);
        chk(capByte == expByte, {curReq, " R9 frame byte"}, capByte, expByte);
        chk(posEnN == ~(NP'(1) << expPos), "R4 position order", posEnN, ~(NP'(1) << expPos));
        if (!firstFrame) chk(gapCnt == GAP, "R6 dark gap", gapCnt, GAP);
        firstFrame = 1'b0;
        bitCount = 0;
        dwellCnt = 1;
      end else if (lit && prevLit) begin
        dwellCnt++;
      end else if (!lit && prevLit) begin
        chk(dwellCnt == DWELL, "R5 dwell length", dwellCnt, DWELL);
        expPos = (expPos + 1) % NP;
        expByte = shadow[expPos];
        gapCnt = 1;
      end else begin
        gapCnt++;
      end
      prevSclk = sclk;
      prevLit = lit;
    end
  end

  task automatic waitShow(input int p);
    do @(negedge clk); while (posEnN[p] !== 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wrTo(input int a, input logic [SW-1:0] d);
    wrEn = 1'b1;
    wrAddr = 3'(a);
    wrData = d;
    if (a < NP) shadow[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    for (int i = 0; i < NP; i++) shadow[i] = '1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(posEnN == 5'h1f, "R1 enables after reset", posEnN, 5'h1f);
    chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
    // R1: first round shows reset contents FF
    for (int p = 0; p < NP; p++) waitShow(p);
    waitShow(0);
    curReq = "R7";
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < NP; p++) begin
        waitShow(p);
        wrTo(p, SW'(r * 37 + p * 53 + 11));
        wrTo((p + 1) % NP, SW'(r * 91 + p * 29 + 3));
      end
    end
    waitShow(1);
    wrTo(2, 8'h00);
    waitShow(2);
    curReq = "R8";
    wrTo(5, 8'h5a);
    wrTo(6, 8'h00);
    wrTo(7, 8'hc3);
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < NP; p++) waitShow(p);
    waitShow(0);
    finish();
  end
endmodule